// File: doc/BRIEF.md
# Shared-Memory CPU Wait-State Generator

This block sits between an 8-bit microprocessor and a DRAM that the CPU shares with a video controller. The memory schedule alternates a CPU slot and a video slot, five CPU T states in total. A CPU memory access must have the rising edge that begins its T3 land exactly on the start of a video slot. The block watches the CPU's active-low memory request and refresh strobes together with a phase level from the clock circuitry. On the first T state of each fetch, read or write, it decides whether that access is already aligned. If it is not, it pulls the CPU's active-low WAIT line until the schedule comes round again.

It also produces a column-strobe enable. This enable is high only in CPU slots in which the CPU really addresses memory, and low in every video slot. Refresh cycles, where the CPU drives refresh and memory request low together, never cause a wait and never open the column strobe. DRAM refresh itself, video addressing and address multiplexing are handled elsewhere.

Top module: `cpu_wait_gen`

## Requirements
- R1: While `rst_n` is low, `wait_n_o` is 1 and `col_en_o` is 0.
- R2: An access start is a cycle in which `mreq_n_i` is sampled 0, `mreq_n_i` was sampled 1 on the previous edge, and `rfsh_n_i` is sampled 1.
- R3: A slot start is a cycle in which `slot_cpu_i` (1 = CPU slot, 0 = video slot) is sampled 1 after being sampled 0 on the previous edge. An access start that coincides with a slot start leaves `wait_n_o` at 1 on the next cycle.
- R4: An access start that is not on a slot start drives `wait_n_o` to 0 on the following cycle.
- R5: Once low, `wait_n_o` stays low until a slot start is sampled, and it is 1 on the cycle after that slot start.
- R6: A falling `mreq_n_i` while `rfsh_n_i` is 0 is a refresh cycle and never drives `wait_n_o` low.
- R7: While `mreq_n_i` stays 1 (no memory request), `wait_n_o` never goes low.
- R8: `col_en_o` is 1 on the cycle after an edge that samples `slot_cpu_i`=1, `mreq_n_i`=0 and `rfsh_n_i`=1, and 0 after any other sampled combination in a CPU slot.
- R9: `col_en_o` is 0 on the cycle after any edge that samples `slot_cpu_i`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; all inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_cpu_i | input | 1 | Schedule phase: 1 in the CPU slot, 0 in the video slot |
| mreq_n_i | input | 1 | CPU memory request, active low |
| rfsh_n_i | input | 1 | CPU refresh strobe, active low |
| wait_n_o | output | 1 | WAIT to the CPU, active low |
| col_en_o | output | 1 | Column-strobe enable, high in a CPU slot with a real memory access |

## Verification
Directed sequences start an access on the first T state of the CPU slot and on every other position of the five-state frame. This separates the aligned case, where there is no wait, from the misaligned cases, where a wait is held until the next CPU-slot start. A refresh that lowers memory request shows that refresh is excluded from both the wait and the column strobe. Long stretches with memory request held high show that idle cycles leave both outputs quiet. Random request and refresh patterns over the running frame then mix back-to-back accesses, a request that falls on a slot start while a wait is still pending, and refresh that overlaps a CPU slot. Each cycle is checked against a reference built from the rules above.

// File: rtl/cpu_wait_gen_pkg.sv
package cpu_wait_gen_pkg;

  // Meaning of the schedule phase level.
  typedef enum logic {
    SLOT_VIDEO = 1'b0,
    SLOT_CPU   = 1'b1
  } slot_e;

  // Number of flops in the reset release chain.
  localparam int unsigned RST_STAGES = 2;

endpackage

// File: rtl/cpu_wait_gen_rst_sync.sv
module cpu_wait_gen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST:0], 1'b1};
    if (STAGES == 1) chain_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d[LAST:0];
  end

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/cpu_wait_gen_edges.sv
module cpu_wait_gen_edges
  import cpu_wait_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slot_cpu,
  input  logic mreq_n,
  input  logic rfsh_n,
  output logic acc_start,
  output logic slot_start
);

  logic mreq_n_q, mreq_n_d;
  logic slot_q,   slot_d;

  always_comb begin
    mreq_n_d = mreq_n;
    slot_d   = slot_cpu;
  end

  // Previous-cycle copies; reset to idle values so that no edge is seen
  // on the first cycle after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mreq_n_q <= 1'b1;
      slot_q   <= SLOT_CPU;
    end else begin
      mreq_n_q <= mreq_n_d;
      slot_q   <= slot_d;
    end
  end

  assign acc_start  = mreq_n_q & ~mreq_n & rfsh_n;
  assign slot_start = (slot_q == SLOT_VIDEO) & (slot_cpu == SLOT_CPU);

endmodule

// File: rtl/cpu_wait_gen_wait.sv
module cpu_wait_gen_wait (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_start,
  input  logic slot_start,
  output logic wait_req
);

  logic wait_q, wait_d;

  always_comb begin
    wait_d = wait_q;
    if (slot_start)     wait_d = 1'b0;
    else if (acc_start) wait_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= wait_d;
  end

  assign wait_req = wait_q;

  // R4
  misaligned_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !slot_start) |=> wait_q);

  // R5
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !slot_start) |=> wait_q);

endmodule

// File: rtl/cpu_wait_gen_col.sv
module cpu_wait_gen_col
  import cpu_wait_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slot_cpu,
  input  logic mreq_n,
  input  logic rfsh_n,
  output logic col_en
);

  logic col_q, col_d;
  logic cpu_slot;

  always_comb begin
    cpu_slot = (slot_cpu == SLOT_CPU);
    col_d    = cpu_slot & ~mreq_n & rfsh_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= 1'b0;
    else        col_q <= col_d;
  end

  assign col_en = col_q;

  // R9
  video_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cpu == SLOT_VIDEO) |=> !col_q);

  // R8
  no_request_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n || !rfsh_n) |=> !col_q);

endmodule

// File: rtl/cpu_wait_gen.sv
module cpu_wait_gen
  import cpu_wait_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic slot_cpu_i,
  input  logic mreq_n_i,
  input  logic rfsh_n_i,
  output logic wait_n_o,
  output logic col_en_o
);

  logic rst_sync_n;
  logic acc_start;
  logic slot_start;
  logic wait_req;
  logic col_en;

  cpu_wait_gen_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cpu_wait_gen_edges u_edges (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .slot_cpu   (slot_cpu_i),
    .mreq_n     (mreq_n_i),
    .rfsh_n     (rfsh_n_i),
    .acc_start  (acc_start),
    .slot_start (slot_start)
  );

  cpu_wait_gen_wait u_wait (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .acc_start  (acc_start),
    .slot_start (slot_start),
    .wait_req   (wait_req)
  );

  cpu_wait_gen_col u_col (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .slot_cpu (slot_cpu_i),
    .mreq_n   (mreq_n_i),
    .rfsh_n   (rfsh_n_i),
    .col_en   (col_en)
  );

  assign wait_n_o = ~wait_req;
  assign col_en_o = col_en;

  // R3
  aligned_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_start && slot_start) |=> wait_n_o);

  // R5
  release_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    slot_start |=> wait_n_o);

  // R6
  refresh_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rfsh_n_i && wait_n_o) |=> wait_n_o);

  // R7
  idle_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mreq_n_i && wait_n_o) |=> wait_n_o);

endmodule

// File: tb/sim_cpu_wait_gen.sv
`timescale 1ns/1ps
module sim_cpu_wait_gen;

  logic clk = 1'b0;
  logic rst_n;
  logic slot_cpu, mreq_n, rfsh_n;
  logic wait_n, col_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  logic pm, pp;          // previous sampled mreq_n / phase
  logic ew, ec;          // expected wait_n and col_en
  string tw, tc;         // requirement each expectation follows
  int pos = 0;           // position in the five-state frame

  always #2 clk = ~clk;  // 250 MHz

  cpu_wait_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_cpu_i (slot_cpu),
    .mreq_n_i   (mreq_n),
    .rfsh_n_i   (rfsh_n),
    .wait_n_o   (wait_n),
    .col_en_o   (col_en)
  );

  function automatic logic frame_phase(input int p);
    return (p < 2);
  endfunction

  function automatic logic next_wait_n(input logic cur, input logic prev_m,
                                       input logic m, input logic r,
                                       input logic prev_p, input logic p);
    logic start, slot;
    start = prev_m & ~m & r;
    slot  = ~prev_p & p;
    if (slot)       return 1'b1;
    else if (start) return 1'b0;
    return cur;
  endfunction

  function automatic logic next_col(input logic p, input logic m, input logic r);
    return p & ~m & r;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One CPU cycle: check at the falling edge, drive, then advance the model.
  task automatic step(input logic m, input logic r, input logic p_override, input bit use_frame);
    logic p;
    @(negedge clk);
    check(wait_n, ew, tw, "wait_n");
    check(col_en, ec, tc, "col_en");
    p = use_frame ? frame_phase(pos) : p_override;
    mreq_n = m; rfsh_n = r; slot_cpu = p;
    @(posedge clk);
    if (~pp & p)           tw = (pm & ~m & r) ? "R3" : "R5";
    else if (pm & ~m & r)  tw = "R4";
    else if (pm & ~m & ~r) tw = "R6";
    else if (m)            tw = (ew) ? "R7" : "R5";
    else                   tw = (ew) ? "R2" : "R5";
    ew = next_wait_n(ew, pm, m, r, pp, p);
    ec = next_col(p, m, r);
    tc = p ? "R8" : "R9";
    pm = m; pp = p;
    pos = (pos == 4) ? 0 : pos + 1;
  endtask

  // Run idle cycles until the frame reaches the given position.
  task automatic go_to(input int target);
    while (pos != target) step(1'b1, 1'b1, 1'b0, 1);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; mreq_n = 1'b1; rfsh_n = 1'b1; slot_cpu = 1'b1;
    pm = 1'b1; pp = 1'b1; ew = 1'b1; ec = 1'b0; tw = "R1"; tc = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wait_n, 1'b1, "R1", "wait_n in reset");
    check(col_en, 1'b0, "R1", "col_en in reset");
    // drive a request during reset: outputs must stay inactive
    mreq_n = 1'b0; slot_cpu = 1'b1;
    @(posedge clk); @(negedge clk);
    check(wait_n, 1'b1, "R1", "wait_n in reset with request");
    check(col_en, 1'b0, "R1", "col_en in reset with request");
    mreq_n = 1'b1;
    rst_n = 1'b1;
    // idle through the reset release chain
    repeat (4) step(1'b1, 1'b1, 1'b1, 0);
    // settle into the frame: phase low first so the first slot start is real
    pos = 2;
    repeat (5) step(1'b1, 1'b1, 1'b0, 1);

    // R3: aligned access starting at the first CPU T state
    go_to(0);
    step(1'b0, 1'b1, 1'b0, 1);
    repeat (3) step(1'b0, 1'b1, 1'b0, 1);
    repeat (3) step(1'b1, 1'b1, 1'b0, 1);

    // R4/R5: misaligned starts at every other frame position
    for (int k = 1; k < 5; k++) begin
      go_to(k);
      step(1'b0, 1'b1, 1'b0, 1);
      repeat (7) step(1'b0, 1'b1, 1'b0, 1);
      repeat (3) step(1'b1, 1'b1, 1'b0, 1);
    end

    // R6: refresh falling edges in every position
    for (int k = 0; k < 5; k++) begin
      go_to(k);
      step(1'b0, 1'b0, 1'b0, 1);
      step(1'b0, 1'b0, 1'b0, 1);
      step(1'b1, 1'b1, 1'b0, 1);
    end

    // R7: long idle stretch
    repeat (20) step(1'b1, 1'b1, 1'b0, 1);

    // R8/R9: request held low across several frames
    go_to(3);
    repeat (12) step(1'b0, 1'b1, 1'b0, 1);
    repeat (2) step(1'b1, 1'b1, 1'b0, 1);

    // random mix over the running frame
    for (int i = 0; i < 4000; i++) begin
      logic m, r;
      m = ($urandom % 3) == 0;
      r = ($urandom % 4) != 0;
      step(m, r, 1'b0, 1);
    end

    // random phase as well, to cover irregular slot edges
    for (int i = 0; i < 1000; i++) begin
      step($urandom % 2, ($urandom % 4) != 0, $urandom % 2, 0);
    end

    step(1'b1, 1'b1, 1'b0, 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule